// File: doc/BRIEF.md
# Effective Address Decoder

This unit sits behind an instruction fetcher. It takes the operand addressing byte that follows an opcode, plus any displacement bytes after it. It then produces the 16-bit effective address, the default segment choice, the 3-bit column field and the number of bytes it has consumed. The fetcher streams bytes one per cycle, qualified by a valid strobe, and idle cycles are allowed between them. The eight 16-bit general registers come in on a flat bus, and the unit samples them in the cycle that delivers the final byte.

Bits 7:6 of the addressing byte give the mode and bits 2:0 give the base/index selector. Register-operand forms consume no displacement. For these the unit reports the selected register number together with its byte-register interpretation. Register slot `i` of the register bus occupies bits `[16*i+15:16*i]`, in the order AX, CX, DX, BX, SP, BP, SI, DI.

Top module: `ea_decode`

## Requirements
- R1: The number of bytes consumed (`used_bytes`) follows bits 7:6 of the addressing byte. Mode 00 consumes 1 byte, except for the direct form. Mode 01 consumes 2. Mode 10 consumes 3. Mode 11 consumes 1.
- R2: In the memory modes, the base for selector values 0 to 7 is, in order: BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX.
- R3: In mode 01, the single displacement byte is sign-extended to 16 bits before it is added to the base.
- R4: In mode 10, the two displacement bytes arrive low byte first and are added to the base.
- R5: Mode 00 with selector 6 is the direct form. The address is the next two bytes, low byte first, with no register added, and 3 bytes are consumed.
- R6: `seg_ss` is 1 when BP is part of the address (selectors 2 and 3 in any memory mode, and selector 6 in modes 01 and 10). It is 0 for every other memory form, including the direct form.
- R7: `col` equals bits 5:3 of the addressing byte in every mode.
- R8: In mode 11, `is_reg` is 1, `ea` is 0 and `seg_ss` is 0. `reg_sel` holds bits 2:0 of the addressing byte. In the byte-register view, `byte_hi` is bit 2 (1 selects the upper half) and `byte_base` is bits 1:0 (the register that holds the byte).
- R9: The address sum wraps modulo 65536.
- R10: `done` is high for exactly one cycle, the cycle after the edge that accepts the last required byte. The result outputs hold their values until the next `done`. Cycles with `byte_valid` low are ignored.
- R11: After reset, `done` is low and the unit expects a fresh addressing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | `byte_in` carries a stream byte this cycle |
| byte_in | input | 8 | Stream byte |
| regs | input | 128 | Eight 16-bit registers, slot i at [16*i+15:16*i] |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address (0 in register mode) |
| seg_ss | output | 1 | 1 = stack segment default, 0 = data segment |
| col | output | 3 | Bits 5:3 of the addressing byte |
| is_reg | output | 1 | Register-operand form |
| reg_sel | output | 3 | Register number in register mode |
| byte_hi | output | 1 | Byte view: upper half selected |
| byte_base | output | 2 | Byte view: register holding the byte |
| used_bytes | output | 2 | Bytes consumed, 1 to 3 |

## Verification
A stuck or misdirected sequencing state shows up at the ports on the very next accepted byte. If the state is wrong, `done` arrives one byte early or late, or `used_bytes` disagrees with the mode. The next instruction's addressing byte would then be absorbed as a displacement, which corrupts every following result. A wrong latched addressing byte or a wrong low displacement byte appears in `ea`, `col` or `seg_ss` in the `done` cycle of that same instruction. The bench therefore checks `done` after every byte, not only after the last one.

// File: rtl/ea_decode.sv
module ea_decode #(
  parameter int RW = 16,
  parameter int NR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  input  logic [RW*NR-1:0] regs,
  output logic             done,
  output logic [RW-1:0]    ea,
  output logic             seg_ss,
  output logic [2:0]       col,
  output logic             is_reg,
  output logic [2:0]       reg_sel,
  output logic             byte_hi,
  output logic [1:0]       byte_base,
  output logic [1:0]       used_bytes
);
  localparam int IX_BX = 3, IX_BP = 5, IX_SI = 6, IX_DI = 7;

  typedef enum logic [1:0] {ST_OP, ST_LO, ST_HI} st_t;
  st_t st_q, st_d;
  logic [7:0] mrm_q, lo_q;

  logic [7:0]    mb;
  logic [1:0]    md, extra;
  logic [2:0]    rm;
  logic          direct, last, ss_d;
  logic [RW-1:0] base, disp;

  function automatic logic [RW-1:0] rv(input int i);
    return regs[RW*i +: RW];
  endfunction

  assign mb     = (st_q == ST_OP) ? byte_in : mrm_q;
  assign md     = mb[7:6];
  assign rm     = mb[2:0];
  assign direct = (md == 2'b00) && (rm == 3'd6);
  assign extra  = (md == 2'b01) ? 2'd1 : ((md == 2'b10) || direct) ? 2'd2 : 2'd0;
  assign last   = byte_valid && ((st_q == ST_OP && extra == 2'd0) ||
                                 (st_q == ST_LO && extra == 2'd1) ||
                                 (st_q == ST_HI));
  assign disp   = (st_q == ST_HI) ? {byte_in, lo_q} :
                  (st_q == ST_LO) ? {{(RW-8){byte_in[7]}}, byte_in} : '0;

  always_comb begin
    case (rm)
      3'd0:    base = rv(IX_BX) + rv(IX_SI);
      3'd1:    base = rv(IX_BX) + rv(IX_DI);
      3'd2:    base = rv(IX_BP) + rv(IX_SI);
      3'd3:    base = rv(IX_BP) + rv(IX_DI);
      3'd4:    base = rv(IX_SI);
      3'd5:    base = rv(IX_DI);
      3'd6:    base = direct ? '0 : rv(IX_BP);
      default: base = rv(IX_BX);
    endcase
  end

  assign ss_d = (md != 2'b11) && ((rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && !direct));

  always_comb begin
    st_d = st_q;
    if (byte_valid) begin
      case (st_q)
        ST_OP:   st_d = (extra == 2'd0) ? ST_OP : ST_LO;
        ST_LO:   st_d = (extra == 2'd1) ? ST_OP : ST_HI;
        default: st_d = ST_OP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_OP;
      mrm_q      <= '0;
      lo_q       <= '0;
      done       <= 1'b0;
      ea         <= '0;
      seg_ss     <= 1'b0;
      col        <= '0;
      is_reg     <= 1'b0;
      reg_sel    <= '0;
      byte_hi    <= 1'b0;
      byte_base  <= '0;
      used_bytes <= '0;
    end else begin
      st_q <= st_d;
      done <= last;
      if (byte_valid && st_q == ST_OP) mrm_q <= byte_in;
      if (byte_valid && st_q == ST_LO) lo_q  <= byte_in;
      if (last) begin
        is_reg     <= (md == 2'b11);
        ea         <= (md == 2'b11) ? '0 : base + disp;
        seg_ss     <= ss_d;
        col        <= mb[5:3];
        reg_sel    <= rm;
        byte_hi    <= rm[2];
        byte_base  <= rm[1:0];
        used_bytes <= extra + 2'd1;
      end
    end
  end
endmodule

// File: rtl/ea_decode_checker.sv
module ea_decode_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        done,
  input logic [15:0] ea,
  input logic        seg_ss,
  input logic        is_reg,
  input logic [2:0]  reg_sel,
  input logic        byte_hi,
  input logic [1:0]  byte_base,
  input logic [1:0]  used_bytes
);
  assert_used_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (used_bytes != 2'd0));

  assert_reg_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_reg) |-> (used_bytes == 2'd1 && ea == 16'd0 && !seg_ss));

  assert_reg_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_reg) |-> ({byte_hi, byte_base} == reg_sel));

  assert_done_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(byte_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea) && $stable(used_bytes) && $stable(is_reg));
endmodule

bind ea_decode ea_decode_checker u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .done(done), .ea(ea),
  .seg_ss(seg_ss), .is_reg(is_reg), .reg_sel(reg_sel), .byte_hi(byte_hi),
  .byte_base(byte_base), .used_bytes(used_bytes));

// File: tb/tb_ea_decode.sv
module tb_ea_decode;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         byte_valid = 0;
  logic [7:0]   byte_in = 0;
  logic [127:0] regs;
  logic         done, seg_ss, is_reg, byte_hi;
  logic [15:0]  ea;
  logic [2:0]   col, reg_sel;
  logic [1:0]   byte_base, used_bytes;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ea_decode dut (.clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .regs(regs), .done(done), .ea(ea), .seg_ss(seg_ss), .col(col), .is_reg(is_reg),
    .reg_sel(reg_sel), .byte_hi(byte_hi), .byte_base(byte_base), .used_bytes(used_bytes));

  localparam logic [15:0] AX = 16'h1000, CX = 16'h2000, DX = 16'h3000, BX = 16'hFFF0,
                          SP = 16'h5000, BP = 16'h0100, SI = 16'h0020, DI = 16'h0003;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    byte_in = b; byte_valid = 1;
    @(posedge clk); @(negedge clk);
    byte_valid = 0;
  endtask

  function automatic logic [15:0] model_base(input logic [2:0] rm, input logic [1:0] md);
    case (rm)
      3'd0: return BX + SI;
      3'd1: return BX + DI;
      3'd2: return BP + SI;
      3'd3: return BP + DI;
      3'd4: return SI;
      3'd5: return DI;
      3'd6: return (md == 2'b00) ? 16'd0 : BP;
      default: return BX;
    endcase
  endfunction

  task automatic run_case(input logic [7:0] m, input logic [15:0] d, input int gap, input string tag);
    logic [1:0] md = m[7:6];
    logic [2:0] rm = m[2:0];
    bit dir = (md == 2'b00 && rm == 3'd6);
    int n = (md == 2'b01) ? 2 : ((md == 2'b10) || dir) ? 3 : 1;
    logic [15:0] dx = (md == 2'b01) ? {{8{d[7]}}, d[7:0]} : (n == 3) ? d : 16'd0;
    logic [15:0] exp_ea = (md == 2'b11) ? 16'd0 : model_base(rm, md) + dx;
    logic exp_ss = (md != 2'b11) && (rm == 3'd2 || rm == 3'd3 || (rm == 3'd6 && !dir));
    send(m);
    for (int i = 1; i < n; i++) begin
      chk({tag, " R10 no early done"}, done, 0);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk({tag, " R10 idle ignored"}, done, 0);
      end
      send(i == 1 ? d[7:0] : d[15:8]);
    end
    chk({tag, " R10 done"}, done, 1);
    chk({tag, " R1 used_bytes"}, used_bytes, n);
    chk({tag, " R2/R3/R4/R5/R9 ea"}, ea, exp_ea);
    chk({tag, " R6 seg_ss"}, seg_ss, exp_ss);
    chk({tag, " R7 col"}, col, m[5:3]);
    chk({tag, " R8 is_reg"}, is_reg, md == 2'b11);
    @(negedge clk);
    chk({tag, " R10 single pulse"}, done, 0);
    chk({tag, " R10 ea held"}, ea, exp_ea);
  endtask

  task automatic t_reset;
    chk("R11 done after reset", done, 0);
    chk("R11 used_bytes after reset", used_bytes, 0);
  endtask

  task automatic t_all_modes;
    for (int md = 0; md < 3; md++)
      for (int rm = 0; rm < 8; rm++)
        run_case({md[1:0], 3'(rm), 3'(rm)}, 16'h1234, 0, "R2 sweep");
  endtask

  task automatic t_sign;
    run_case(8'b01_101_111, 16'h0080, 0, "R3 neg d8");
    run_case(8'b01_000_100, 16'h00FF, 0, "R3 -1 d8");
    run_case(8'b01_000_100, 16'h007F, 0, "R3 pos d8");
  endtask

  task automatic t_direct;
    run_case(8'b00_011_110, 16'hBEEF, 0, "R5 direct");
    run_case(8'b10_011_110, 16'h0010, 0, "R6 BP d16");
  endtask

  task automatic t_reg;
    for (int rm = 0; rm < 8; rm++) begin
      run_case({2'b11, 3'd5, 3'(rm)}, 16'h0, 0, "R8 reg");
      chk("R8 reg_sel", reg_sel, rm);
      chk("R8 byte_hi", byte_hi, rm >> 2);
      chk("R8 byte_base", byte_base, rm & 3);
    end
  endtask

  task automatic t_wrap;
    run_case(8'b10_000_000, 16'hFFFF, 0, "R9 wrap");
    run_case(8'b10_000_111, 16'h0020, 0, "R9 wrap BX");
  endtask

  task automatic t_gaps;
    run_case(8'b10_001_010, 16'hA55A, 3, "R4 gaps");
    run_case(8'b01_010_001, 16'h0090, 2, "R3 gaps");
  endtask

  task automatic t_back_to_back;
    send(8'b11_000_001);
    chk("R10 b2b first done", done, 1);
    send(8'b00_001_100);
    chk("R10 b2b second done", done, 1);
    chk("R2 b2b ea SI", ea, SI);
    chk("R1 b2b used_bytes", used_bytes, 1);
    @(negedge clk);
    chk("R10 b2b end", done, 0);
  endtask

  initial begin
    regs = {DI, SI, BP, SP, BX, DX, CX, AX};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_all_modes();
    t_sign();
    t_direct();
    t_reg();
    t_wrap();
    t_gaps();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule